// File: doc/BRIEF.md
# Multi-Duty LCD Scan Controller

This block scans a multiplexed liquid-crystal panel from a small nibble-wide display store. A narrow register bus, with 4-bit data and 8-bit addresses, reaches a control register, a display-override register, a contrast register and a 160-word by 4-bit display memory. A frame-rate enable input steps a common-line sequencer through the commons of the selected duty (four, five or eight lines). For the active common, every segment output takes the level of its dot bit.

All drive outputs are digital on/off selections. Analog level generation lies outside the block. The contrast setting is only held and presented on an output for the analog side to use. A power gate, a static single-common mode and two whole-panel overrides change what the scan produces.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: After reset, the control, override and contrast registers read 0, and `com_o`, `seg_o` and `contrast_o` are all 0.
- R2: The control register sits at address 0xA0. Bit 0 is power enable, bit 1 selects static mode (1 = static), and bits 3:2 are the duty code. It reads back as written.
- R3: While power enable is 0, every bit of `com_o` and `seg_o` is 0, whatever the other settings, the memory contents or the ticks.
- R4: The duty code selects the number of commons: 00 gives four (COM0–COM3), 01 gives five (COM0–COM4), and 10 or 11 gives eight (COM0–COM7). In dynamic mode with power on, exactly one `com_o` bit is high. The active common moves up by one per `frame_tick` and returns to COM0 after the last common of the duty. Commons beyond the duty stay low.
- R5: The level of segment s while common c is active is bit (c mod 4) of the memory word at address 2*s + floor(c/4).
- R6: The override register sits at address 0xA1. Bit 2 forces all segments low, and bit 1 forces all segments high. When both are set, forcing low wins. Bits 3 and 0 always read 0.
- R7: The contrast register sits at address 0xA2. It holds a 4-bit value, reads back as written, and appears unchanged on `contrast_o`.
- R8: Addresses 0x00–0x9F read and write the 160 display words. Reads from unmapped addresses return 0, and writes to them change nothing.
- R9: In static mode with power on, all eight `com_o` bits are high, and segment s takes bit 0 of word 2*s.
- R10: A new duty code written while scanning takes effect only when the current frame wraps, and the next frame starts at COM0.
- R11: `bus_rdata` shows the contents of the address presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Register bus address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, one clock after the address |
| frame_tick | input | 1 | Single-cycle enable that advances the common line |
| com_o | output | 8 | Common-line drive selects |
| seg_o | output | 64 | Segment-line drive selects |
| contrast_o | output | 4 | Stored contrast setting |

## Verification
The bench aims at four corner cases.

- **Duty change partway through a frame.** A design that switches duty at once would jump straight to COM0 or stop short of COM7 instead of finishing the eight-line frame.
- **Both overrides set together.** A wrong priority would light the whole panel.
- **Power cycling while ticks keep arriving.** A leak through the gate would show active commons, or the sequencer would resume partway through a frame.
- **Mixed duty codes, static mode and random memory contents.** A wrong dot address (word for commons 4–7, or bit within the word) shows up as segment mismatches on specific commons. The read-only-zero override bits and the unmapped read addresses are also probed, to catch a register that stores bits it should drop.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int COM_N = 8;
  localparam int COM_W = $clog2(COM_N);
  localparam int DATA_W = 4;

  typedef struct packed {
    logic [1:0] duty;
    logic       stat;
    logic       pwr;
  } ctrl_t;

  typedef struct packed {
    logic all_off;
    logic all_on;
  } ovr_t;

  function automatic logic [COM_W-1:0] last_com(input logic [1:0] duty);
    if (duty[1])      return COM_W'(7);
    else if (duty[0]) return COM_W'(4);
    else              return COM_W'(3);
  endfunction
endpackage

// File: rtl/lcd_regs.sv
module lcd_regs
  import lcd_scan_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hA0,
  parameter logic [ADDR_W-1:0] OVR_ADDR  = 8'hA1,
  parameter logic [ADDR_W-1:0] CON_ADDR  = 8'hA2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl,
  output ovr_t              ovr,
  output logic [DATA_W-1:0] contrast,
  output logic [DATA_W-1:0] reg_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      ovr      <= '0;
      contrast <= '0;
    end else if (we) begin
      if (addr == CTRL_ADDR) ctrl     <= ctrl_t'(wdata);
      if (addr == OVR_ADDR)  ovr      <= '{all_off: wdata[2], all_on: wdata[1]};
      if (addr == CON_ADDR)  contrast <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      CTRL_ADDR: reg_rdata = DATA_W'(ctrl);
      OVR_ADDR:  reg_rdata = {1'b0, ovr.all_off, ovr.all_on, 1'b0};
      CON_ADDR:  reg_rdata = contrast;
      default:   reg_rdata = '0;
    endcase
  end

  // Contrast must follow its own bus writes only
  assert_contrast_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == CON_ADDR) |=> $stable(contrast));

  // Control register changes only through a write to its address
  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == CTRL_ADDR) |=> $stable(ctrl));
endmodule

// File: rtl/lcd_dispmem.sv
module lcd_dispmem
  import lcd_scan_pkg::*;
#(
  parameter int WORDS  = 160,
  parameter int ADDR_W = 8,
  parameter int SEGS   = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [COM_W-1:0]  com_sel,
  output logic              hit,
  output logic [DATA_W-1:0] mem_rdata,
  output logic [SEGS-1:0]   dots
);
  localparam int WPS   = (COM_N + DATA_W - 1) / DATA_W;
  localparam int IDX_W = $clog2(WORDS);

  logic [DATA_W-1:0] mem [WORDS];

  assign hit = (int'(addr) < WORDS);

  always_ff @(posedge clk) begin
    if (we && hit) mem[IDX_W'(addr)] <= wdata;
  end

  assign mem_rdata = hit ? mem[IDX_W'(addr)] : '0;

  generate
    for (genvar s = 0; s < SEGS; s++) begin : g_seg
      logic [DATA_W-1:0] word_s;
      assign word_s  = mem[IDX_W'(s * WPS) + IDX_W'(com_sel >> 2)];
      assign dots[s] = word_s[com_sel[1:0]];
    end
  endgenerate
endmodule

// File: rtl/lcd_com_seq.sv
module lcd_com_seq
  import lcd_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr,
  input  logic             tick,
  input  logic [1:0]       duty_req,
  output logic [COM_W-1:0] idx,
  output logic [1:0]       duty_act
);
  logic at_last;
  assign at_last = (idx == last_com(duty_act));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      duty_act <= '0;
    end else if (!pwr) begin
      idx      <= '0;
      duty_act <= duty_req;
    end else if (tick) begin
      if (at_last) begin
        idx      <= '0;
        duty_act <= duty_req;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assert_idx_in_duty_R4: assert property (@(posedge clk) disable iff (rst)
    idx <= last_com(duty_act));

  assert_duty_only_at_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (pwr && !(tick && at_last)) |=> $stable(duty_act));

  assert_off_holds_com0_R3: assert property (@(posedge clk) disable iff (rst)
    !pwr |=> idx == '0);
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int SEGS   = 64,
  parameter int WORDS  = 160,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hA0,
  parameter logic [ADDR_W-1:0] OVR_ADDR  = 8'hA1,
  parameter logic [ADDR_W-1:0] CON_ADDR  = 8'hA2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_wdata,
  output logic [3:0]        bus_rdata,
  input  logic              frame_tick,
  output logic [7:0]        com_o,
  output logic [SEGS-1:0]   seg_o,
  output logic [3:0]        contrast_o
);
  ctrl_t             ctrl;
  ovr_t              ovr;
  logic [DATA_W-1:0] reg_rdata, mem_rdata;
  logic              mem_hit;
  logic [COM_W-1:0]  idx, com_sel;
  logic [1:0]        duty_act;
  logic [SEGS-1:0]   dots;

  lcd_regs #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .OVR_ADDR(OVR_ADDR), .CON_ADDR(CON_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .ctrl(ctrl), .ovr(ovr), .contrast(contrast_o), .reg_rdata(reg_rdata)
  );

  lcd_com_seq u_seq (
    .clk(clk), .rst(rst), .pwr(ctrl.pwr), .tick(frame_tick),
    .duty_req(ctrl.duty), .idx(idx), .duty_act(duty_act)
  );

  assign com_sel = ctrl.stat ? '0 : idx;

  lcd_dispmem #(.WORDS(WORDS), .ADDR_W(ADDR_W), .SEGS(SEGS)) u_mem (
    .clk(clk), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .com_sel(com_sel), .hit(mem_hit), .mem_rdata(mem_rdata), .dots(dots)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      com_o     <= '0;
      seg_o     <= '0;
    end else begin
      bus_rdata <= mem_hit ? mem_rdata : reg_rdata;
      if (!ctrl.pwr) begin
        com_o <= '0;
        seg_o <= '0;
      end else begin
        com_o <= ctrl.stat ? '1 : (8'd1 << idx);
        if (ovr.all_off)     seg_o <= '0;
        else if (ovr.all_on) seg_o <= '1;
        else                 seg_o <= dots;
      end
    end
  end

  assert_power_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !ctrl.pwr |=> (com_o == '0 && seg_o == '0));

  assert_one_common_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.pwr && !ctrl.stat) |=> $countones(com_o) == 1);

  assert_off_beats_on_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.pwr && ovr.all_off) |=> seg_o == '0);

  assert_ovr_zero_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OVR_ADDR) |=> (bus_rdata[3] == 1'b0 && bus_rdata[0] == 1'b0));

  assert_static_commons_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl.pwr && ctrl.stat) |=> com_o == '1);
endmodule

// File: tb/lcd_scan_ctrl_bench.sv
`timescale 1ns/1ps
module lcd_scan_ctrl_bench;
  logic        clk = 0, rst = 1;
  logic        bus_we = 0, frame_tick = 0;
  logic [7:0]  bus_addr = 0;
  logic [3:0]  bus_wdata = 0;
  logic [3:0]  bus_rdata, contrast_o;
  logic [7:0]  com_o;
  logic [63:0] seg_o;

  int n_chk = 0, n_err = 0;

  logic [3:0] m_mem [160];
  logic [3:0] m_ctrl = 0, m_ovr = 0;
  int         m_idx = 0;
  logic [1:0] m_duty = 0;

  always #4 clk = ~clk;

  lcd_scan_ctrl u_lcd_scan_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_tick(frame_tick),
    .com_o(com_o), .seg_o(seg_o), .contrast_o(contrast_o)
  );

  function automatic int last_of(logic [1:0] d);
    return d[1] ? 7 : (d[0] ? 4 : 3);
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
    if (a < 8'd160) m_mem[a] = d;
    if (a == 8'hA1) m_ovr = {1'b0, d[2], d[1], 1'b0};
    if (a == 8'hA0) begin
      m_ctrl = d;
      if (!d[0]) begin m_idx = 0; m_duty = d[3:2]; end
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [3:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
    if (m_ctrl[0]) begin
      if (m_idx == last_of(m_duty)) begin m_idx = 0; m_duty = m_ctrl[3:2]; end
      else m_idx++;
    end
  endtask

  task automatic check_scan(string tag);
    logic [7:0]  ec;
    logic [63:0] es;
    int c;
    repeat (3) @(negedge clk);
    c = m_ctrl[1] ? 0 : m_idx;
    for (int s = 0; s < 64; s++) es[s] = m_mem[2*s + c/4][c%4];
    if (m_ovr[2]) es = '0;
    else if (m_ovr[1]) es = '1;
    ec = m_ctrl[1] ? 8'hFF : (8'd1 << m_idx);
    if (!m_ctrl[0]) begin ec = 0; es = 0; end
    chk({tag, " com"}, 64'(com_o), 64'(ec));
    chk({tag, " seg"}, es === seg_o ? 64'd0 : seg_o, es === seg_o ? 64'd0 : es);
  endtask

  task automatic power_on(logic [1:0] d, logic st);
    wr(8'hA0, {d, st, 1'b0});
    wr(8'hA0, {d, st, 1'b1});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    @(negedge clk);
    chk("R1 com", 64'(com_o), 0);
    chk("R1 seg", seg_o, 0);
    chk("R1 contrast", 64'(contrast_o), 0);
    rd(8'hA0, r); chk("R1 ctrl", 64'(r), 0);
    rd(8'hA1, r); chk("R1 ovr", 64'(r), 0);

    // R8: fill memory and read back
    for (int a = 0; a < 160; a++) wr(8'(a), 4'($urandom));
    for (int k = 0; k < 8; k++) begin
      int a = $urandom % 160;
      rd(8'(a), r); chk("R8 R11 mem read", 64'(r), 64'(m_mem[a]));
    end
    rd(8'd159, r); chk("R8 top word", 64'(r), 64'(m_mem[159]));
    wr(8'hB5, 4'hF);
    rd(8'hB5, r); chk("R8 unmapped", 64'(r), 0);

    // R7: contrast
    wr(8'hA2, 4'hB);
    rd(8'hA2, r); chk("R7 readback", 64'(r), 64'hB);
    chk("R7 output", 64'(contrast_o), 64'hB);

    // R2: control readback (power stays off)
    wr(8'hA0, 4'b1110);
    rd(8'hA0, r); chk("R2 readback", 64'(r), 64'hE);

    // R3: power off with ticks and overrides
    wr(8'hA1, 4'b0010);
    for (int k = 0; k < 3; k++) begin tick(); check_scan("R3 power off"); end
    wr(8'hA1, 4'b0000);

    // R4 R5: each duty code through more than two frames
    for (int d = 0; d < 4; d++) begin
      power_on(2'(d), 1'b0);
      check_scan("R4 R5 start");
      for (int k = 0; k < 19; k++) begin tick(); check_scan("R4 R5 scan"); end
    end

    // R6: overrides and read-only bits
    wr(8'hA1, 4'hF);
    rd(8'hA1, r); chk("R6 ovr readback", 64'(r), 64'h6);
    tick(); check_scan("R6 both set");
    wr(8'hA1, 4'b0010); tick(); check_scan("R6 all on");
    wr(8'hA1, 4'b0100); tick(); check_scan("R6 all off");
    wr(8'hA1, 4'b0000);

    // R9: static mode
    power_on(2'b01, 1'b1);
    for (int k = 0; k < 3; k++) begin tick(); check_scan("R9 static"); end

    // R10: duty change mid-frame
    power_on(2'b10, 1'b0);
    tick(); tick();
    wr(8'hA0, 4'b0001);
    for (int k = 0; k < 10; k++) begin tick(); check_scan("R10 change"); end
    chk("R10 model at COM0 of short frame", 64'(m_idx), 0);

    // Mixed random traffic (R3 R4 R5 R6 R9)
    for (int k = 0; k < 200; k++) begin
      case ($urandom % 6)
        0: wr(8'hA0, 4'($urandom));
        1: wr(8'hA1, 4'($urandom % 16 < 4 ? $urandom : 0));
        2, 3: wr(8'($urandom % 160), 4'($urandom));
        default: tick();
      endcase
      check_scan("R3 R4 R5 R6 R9 random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule